// File: doc/BRIEF.md
# Short-Circuit Event Window Detector

This block sits beside the oscillator of a switching controller and watches for sustained short-circuit conditions. A short-circuit event is a current-limit trip that lands early in the charge phase, while the ramp count is still below a programmable threshold. The block therefore flags only the case where current limit and a shortened duty cycle occur together. Ordinary current limiting late in the pulse does not count.

At each oscillator cycle tick, the block pushes one flag into a 32-cycle sliding history. The flag is set if an event occurred in that cycle. When the number of flagged cycles in the history first reaches 8, the block raises a one-clock shutdown request to the fault sequencer. The history is emptied after a shutdown and whenever detection is disabled. Detection is disabled while soft-start is still running and whenever the threshold code is zero.

The threshold code scales the full charge ramp. A code of `thr_code` places the short-circuit boundary at `thr_code * 2^(RAMP_W-THR_W)` ramp counts. With the defaults this is `thr_code * 16` out of 256. Each code step is therefore 1/16 of the maximum duty, and a zero code disables the function.

The control is a four-state machine:

- **IDLE**: detection is off and the window is held empty.
- **ARMED**: enabled, and no event has been seen yet in the current cycle.
- **CAUGHT**: an event has been latched for the current cycle.
- **TRIP**: the request is driven for one clock.

The transitions are:

- **enable**: IDLE→ARMED, when `ss_done` is high and `thr_code` is non-zero.
- **disable**: ARMED or CAUGHT→IDLE, when that condition drops.
- **catch**: ARMED→CAUGHT, on an event.
- **advance**: ARMED or CAUGHT→ARMED, on a tick that leaves the count below 8.
- **fire**: ARMED or CAUGHT→TRIP, on a tick that brings the count to 8.
- **recover**: TRIP→IDLE.

Top module: `scwd_detect`

## Requirements
- R1: After reset, `sc_req` is low and the event history is empty.
- R2: An event is counted when `cur_lim` is high during the charge phase while `ramp_cnt < thr_code * 2^(RAMP_W-THR_W)`. A current-limit flag at or above that ramp count is not an event.
- R3: The charge phase starts on the clock where `charge_start` is sampled high and ends at the next `cyc_tick`. A `cur_lim` outside the charge phase is ignored.
- R4: At most one event is counted per oscillator cycle, however many clocks `cur_lim` is held.
- R5: On the `cyc_tick` that brings the number of event cycles among the last 32 ticks to 8, `sc_req` goes high on the following clock.
- R6: An event cycle stops counting once it is older than the last 32 ticks. Events spaced 5 cycles apart never produce a request.
- R7: A zero `thr_code` disables detection and empties the history.
- R8: A low `ss_done` disables detection and empties the history, so a new soft-start begins with no past events.
- R9: `sc_req` lasts exactly one clock, and the history is empty after a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ramp_cnt | input | RAMP_W | Position within the charge ramp |
| charge_start | input | 1 | Pulse marking the start of a charge phase |
| thr_code | input | THR_W | Short-circuit duty threshold code; zero disables |
| cur_lim | input | 1 | Current-limit comparator flag |
| cyc_tick | input | 1 | Pulse marking the end of an oscillator cycle |
| ss_done | input | 1 | Soft-start complete |
| sc_req | output | 1 | One-clock shutdown request |

## Verification
The bench sweeps every threshold code against ramp positions and targets the exact boundary where the ramp equals the limit. A design with an off-by-one comparison would count an event one step too late or too early.

It holds current limit for several clocks in one cycle and injects current limit between a tick and the next charge start. An implementation that counted per clock, or ignored the charge phase, would shut down early.

Events are spaced 4 and 5 cycles apart to probe the window edge. A window that never retires old flags would fire on the 5-cycle spacing, and one that is too short would miss the 4-cycle spacing.

Disabling through `ss_done` or `thr_code` partway through a window is followed by 7 fresh events. A design that kept its history would fire there.

// File: rtl/scwd_pkg.sv
`timescale 1ns/1ps
package scwd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_CAUGHT,
        ST_TRIP
    } scwd_state_t;
endpackage

// File: rtl/scwd_classify.sv
`timescale 1ns/1ps
// Classifies current-limit flags inside the charge phase against the scaled duty limit.
module scwd_classify #(
    parameter int RAMP_W = 8,
    parameter int THR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAMP_W-1:0] ramp_cnt,
    input  logic [THR_W-1:0]  thr_code,
    input  logic              charge_start,
    input  logic              cyc_tick,
    input  logic              cur_lim,
    input  logic              ss_done,
    output logic              enable,
    output logic              hit
);
    localparam int SHIFT = RAMP_W - THR_W;

    logic [RAMP_W-1:0] limit;
    logic              in_charge;

    generate
        if (SHIFT > 0) begin : g_scaled
            assign limit = {thr_code, {SHIFT{1'b0}}};
        end else begin : g_direct
            assign limit = thr_code;
        end
    endgenerate

    // charge phase: opened by charge_start, closed by the cycle tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_charge <= 1'b0;
        end else if (charge_start) begin
            in_charge <= 1'b1;
        end else if (cyc_tick) begin
            in_charge <= 1'b0;
        end
    end

    always_comb begin
        enable = ss_done && (thr_code != '0);
        hit    = enable && in_charge && cur_lim && (ramp_cnt < limit);
    end

    // R3: after a tick with no new charge start, no event may be classified
    p_no_hit_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc_tick) && !$past(charge_start)) |-> !hit);

    // R2: an event always comes from an active current-limit flag
    p_hit_needs_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cur_lim && ss_done));
endmodule

// File: rtl/scwd_window.sv
`timescale 1ns/1ps
// Sliding history of per-cycle event flags with a running population count.
module scwd_window #(
    parameter int WIN   = 32,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             bit_in,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic [WIN-1:0] hist;

    always_comb begin
        cnt_nxt = cnt;
        if (push) begin
            cnt_nxt = cnt + CNT_W'(bit_in) - CNT_W'(hist[WIN-1]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
            cnt  <= '0;
        end else if (clr) begin
            hist <= '0;
            cnt  <= '0;
        end else if (push) begin
            hist <= {hist[WIN-2:0], bit_in};
            cnt  <= cnt_nxt;
        end
    end

    // R6: the running count always equals the flags still inside the window
    p_count_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) == $countones(hist));

    // R6: the count never exceeds the window length
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) <= WIN);
endmodule

// File: rtl/scwd_detect.sv
`timescale 1ns/1ps
// Short-circuit event window detector: state machine over classifier and window.
module scwd_detect #(
    parameter int RAMP_W = 8,
    parameter int THR_W  = 4,
    parameter int WIN    = 32,
    parameter int NEED   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RAMP_W-1:0] ramp_cnt,
    input  logic              charge_start,
    input  logic [THR_W-1:0]  thr_code,
    input  logic              cur_lim,
    input  logic              cyc_tick,
    input  logic              ss_done,
    output logic              sc_req
);
    import scwd_pkg::*;

    localparam int CNT_W = $clog2(WIN + 1);

    scwd_state_t      state_q, state_d;
    logic             en, hit;
    logic             push, bit_in, clr;
    logic [CNT_W-1:0] win_cnt, win_nxt;

    scwd_classify #(.RAMP_W(RAMP_W), .THR_W(THR_W)) u_cls (
        .clk          (clk),
        .rst_n        (rst_n),
        .ramp_cnt     (ramp_cnt),
        .thr_code     (thr_code),
        .charge_start (charge_start),
        .cyc_tick     (cyc_tick),
        .cur_lim      (cur_lim),
        .ss_done      (ss_done),
        .enable       (en),
        .hit          (hit)
    );

    scwd_window #(.WIN(WIN), .CNT_W(CNT_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .push    (push),
        .bit_in  (bit_in),
        .cnt     (win_cnt),
        .cnt_nxt (win_nxt)
    );

    always_comb begin
        push   = en && cyc_tick && (state_q == ST_ARMED || state_q == ST_CAUGHT);
        bit_in = (state_q == ST_CAUGHT) || hit;
        clr    = (state_q == ST_IDLE) || (state_q == ST_TRIP);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en)                                state_d = ST_IDLE;
                else if (cyc_tick && win_nxt >= CNT_W'(NEED)) state_d = ST_TRIP;
                else if (cyc_tick)                      state_d = ST_ARMED;
                else if (hit)                           state_d = ST_CAUGHT;
            end
            ST_CAUGHT: begin
                if (!en)                                state_d = ST_IDLE;
                else if (cyc_tick && win_nxt >= CNT_W'(NEED)) state_d = ST_TRIP;
                else if (cyc_tick)                      state_d = ST_ARMED;
            end
            ST_TRIP: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output logic
    always_comb begin
        sc_req = (state_q == ST_TRIP);
    end

    // R9: request is a single-clock pulse
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> !sc_req);

    // R9: history is empty after the request
    p_window_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |=> (win_cnt == '0));

    // R5: a request follows a cycle tick
    p_trip_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |-> $past(cyc_tick));

    // R8: no request unless soft-start had completed
    p_trip_needs_ss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |-> $past(ss_done));

    // R7: no request from a zero threshold code
    p_trip_needs_thr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req |-> ($past(thr_code) != '0));

    // R4: a caught cycle stays caught until its tick
    p_one_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_CAUGHT && !$past(cyc_tick) && $past(en))
        |-> (state_q == ST_CAUGHT));
endmodule

// File: tb/scwd_detect_test.sv
`timescale 1ns/1ps
module scwd_detect_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] ramp_cnt;
    logic       charge_start;
    logic [3:0] thr_code;
    logic       cur_lim;
    logic       cyc_tick;
    logic       ss_done;
    logic       sc_req;

    int  checks = 0;
    int  errors = 0;
    bit  hist [32];

    always #2.5 clk = ~clk;

    scwd_detect uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ramp_cnt     (ramp_cnt),
        .charge_start (charge_start),
        .thr_code     (thr_code),
        .cur_lim      (cur_lim),
        .cyc_tick     (cyc_tick),
        .ss_done      (ss_done),
        .sc_req       (sc_req)
    );

    task automatic chk(input bit got, input bit exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s sc_req got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_model();
        for (int i = 0; i < 32; i++) hist[i] = 1'b0;
    endtask

    // one oscillator cycle; expected values follow R2..R9
    task automatic osc(input int ramp, input bit lim, input int nhits, input bit pre, input string req);
        bit en, ev, exp;
        int sum;
        if (pre) begin
            ramp_cnt = 8'd0; cur_lim = 1'b1; step(); cur_lim = 1'b0;
        end
        charge_start = 1'b1; step(); charge_start = 1'b0;
        ramp_cnt = 8'(ramp);
        cur_lim  = lim;
        for (int k = 0; k < nhits; k++) step();
        cur_lim  = 1'b0;
        cyc_tick = 1'b1; step(); cyc_tick = 1'b0;
        en  = ss_done && (thr_code != 4'd0);
        ev  = en && lim && (nhits > 0) && (ramp < int'(thr_code) * 16);
        exp = 1'b0;
        if (!en) begin
            clear_model();
        end else begin
            for (int i = 31; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = ev;
            sum = 0;
            for (int i = 0; i < 32; i++) sum += int'(hist[i]);
            if (sum >= 8) begin
                exp = 1'b1;
                clear_model();
            end
        end
        chk(sc_req, exp, req);
        step();
        chk(sc_req, 1'b0, "R9 pulse width");
    endtask

    task automatic set_en(input bit ss, input logic [3:0] thr);
        ss_done  = ss;
        thr_code = thr;
        step(); step();
        if (!(ss && thr != 4'd0)) clear_model();
    endtask

    initial begin
        #750000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ramp_cnt = '0; charge_start = 1'b0; thr_code = '0;
        cur_lim = 1'b0; cyc_tick = 1'b0; ss_done = 1'b0;
        clear_model();
        @(negedge clk);
        step(); step(); step();
        chk(sc_req, 1'b0, "R1 reset");
        rst_n = 1'b1;
        step();
        chk(sc_req, 1'b0, "R1 after reset");

        set_en(1'b1, 4'd8);
        // R5: eight consecutive events trip on the eighth
        for (int c = 0; c < 8; c++) osc(10, 1'b1, 1, 1'b0, "R5 eight in a row");

        // R2: boundary at the limit itself
        for (int c = 0; c < 8; c++) osc(128, 1'b1, 1, 1'b0, "R2 at limit no event");
        for (int c = 0; c < 7; c++) osc(127, 1'b1, 1, 1'b0, "R2 below limit");
        osc(128, 1'b1, 1, 1'b0, "R2 at limit no event");
        osc(127, 1'b1, 1, 1'b0, "R2 eighth below limit");

        // R4: held current limit counts once per cycle
        for (int c = 0; c < 7; c++) osc(5, 1'b1, 4, 1'b0, "R4 multi-clock limit");
        osc(5, 1'b1, 1, 1'b0, "R4 eighth cycle");

        // R3: limit outside the charge phase ignored
        for (int c = 0; c < 10; c++) osc(0, 1'b0, 1, 1'b1, "R3 outside charge");
        for (int c = 0; c < 8; c++) osc(20, 1'b0, 1, 1'b1, "R3 flags before charge");
        for (int c = 0; c < 8; c++) osc(20, 1'b1, 1, 1'b1, "R3 real events");

        // R6: spacing 5 never trips, spacing 4 does
        for (int c = 0; c < 60; c++) osc(3, (c % 5) == 0, 1, 1'b0, "R6 spacing five");
        set_en(1'b0, 4'd8); set_en(1'b1, 4'd8);
        for (int c = 0; c < 32; c++) osc(3, (c % 4) == 0, 1, 1'b0, "R6 spacing four");

        // R7: zero threshold disables and clears history
        for (int c = 0; c < 5; c++) osc(3, 1'b1, 1, 1'b0, "R7 prefill");
        set_en(1'b1, 4'd0);
        for (int c = 0; c < 10; c++) osc(0, 1'b1, 1, 1'b0, "R7 disabled");
        set_en(1'b1, 4'd8);
        for (int c = 0; c < 7; c++) osc(3, 1'b1, 1, 1'b0, "R7 fresh history");
        osc(3, 1'b1, 1, 1'b0, "R7 eighth after enable");

        // R8: soft-start restart clears history
        for (int c = 0; c < 5; c++) osc(3, 1'b1, 1, 1'b0, "R8 prefill");
        set_en(1'b0, 4'd8);
        for (int c = 0; c < 4; c++) osc(3, 1'b1, 1, 1'b0, "R8 during soft-start");
        set_en(1'b1, 4'd8);
        for (int c = 0; c < 7; c++) osc(3, 1'b1, 1, 1'b0, "R8 fresh history");
        osc(3, 1'b1, 1, 1'b0, "R8 eighth after soft-start");

        // R2/R7 sweep of all codes across the ramp
        for (int t = 0; t < 16; t++) begin
            set_en(1'b1, 4'(t));
            for (int r = 0; r < 256; r += 8) osc(r, 1'b1, 1, 1'b0, "R2 sweep");
            if (t > 0) begin
                osc(t * 16 - 1, 1'b1, 1, 1'b0, "R2 sweep just below");
                osc(t * 16, 1'b1, 1, 1'b0, "R2 sweep at limit");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule